// File: doc/BRIEF.md
# Trap Entry and Delegation Unit

This block performs the state update a processor core needs when it takes a trap. A trap can be an interrupt or a synchronous exception. The core presents the request and its current context: the program counter, the privilege level, the interrupt-enable and previous-state status fields, the two delegation masks and the two trap-vector registers. On the clock edge where the request strobe is high, the block decides which privilege level handles the trap. It then commits that level's cause, exception-pc and trap-value registers, the rewritten status fields, the new privilege and the redirected program counter. It also pulses a signal that invalidates any load reservation.

A failed address translation can be fed in directly. The block turns the access kind, the paging state and the protection-violation flag into the correct page-fault or access-fault code. An environment-call exception is reported with a code that depends on the privilege it came from. Privilege codes are user 0, supervisor 1 and machine 3. The block owns the cause, epc and tval registers for both handling levels. The status fields and the program counter are returned to the surrounding register file as registered outputs.

Top module: `trap_entry_unit`

## Requirements
- R1: While `rst` is high at a clock edge, every output is cleared after that edge, except `nxt_priv`, which becomes 3 (machine).
- R2: On an edge where `trap_req` is low, no output register changes and `resv_clear` is low after that edge.
- R3: A trap is handled at supervisor level (`nxt_priv` = 1) only when `cur_priv` is 0 or 1, the effective cause code is below XLEN, and the bit at that code's index is set in `ideleg` (interrupts) or `edeleg` (exceptions). Every other trap is handled at machine level (`nxt_priv` = 3).
- R4: On supervisor entry, `nxt_spie` takes `cur_sie`, `nxt_spp` takes bit 0 of `cur_priv`, and `nxt_sie` becomes 0, while the machine fields copy their inputs. On machine entry, `nxt_mpie` takes `cur_mie`, `nxt_mpp` takes `cur_priv`, and `nxt_mie` becomes 0, while the supervisor fields copy their inputs.
- R5: The handling level's cause, epc (taking `cur_pc`) and tval registers are written, and the other level's three registers keep their values.
- R6: A written cause register holds the effective cause code in its low bits, with bit XLEN-1 set for an interrupt and clear for an exception.
- R7: `nxt_pc` is the handling level's vector with bits 1:0 cleared. When that vector's bits 1:0 equal 1 and the trap is an interrupt, four times the cause code is added.
- R8: tval takes `trap_addr` for exceptions with codes 0, 1, 4, 5, 6, 7, 12, 13 and 15. It is 0 for every other exception and for all interrupts.
- R9: An exception with code 8 is reported as code 8 plus `cur_priv` (8 user, 9 supervisor, 11 machine), and delegation uses the rewritten code.
- R10: With `xlat_fail` high, `trap_cause` and `trap_irq` are ignored and the trap is an exception. The access kind is taken from `xlat_kind`: 0 is fetch, 1 is load, 2 or 3 is store. The fault is a page fault (12, 13, 15 for fetch, load, store) when `paging_on` is high and `prot_fail` is low. Otherwise it is an access fault (1, 5, 7).
- R11: After an edge where `trap_req` is high, `resv_clear` is high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_req | input | 1 | Take a trap on this edge |
| trap_irq | input | 1 | Request is an interrupt |
| trap_cause | input | CW | Raw cause code |
| trap_addr | input | XLEN | Faulting address |
| xlat_fail | input | 1 | Request comes from a failed translation |
| xlat_kind | input | 2 | Access kind of the failed translation |
| paging_on | input | 1 | Address translation is active |
| prot_fail | input | 1 | Failure was a protection check |
| cur_pc | input | XLEN | Program counter of the trapping instruction |
| cur_priv | input | 2 | Current privilege |
| cur_sie | input | 1 | Supervisor interrupt enable |
| cur_spie | input | 1 | Supervisor previous enable |
| cur_spp | input | 1 | Supervisor previous privilege |
| cur_mie | input | 1 | Machine interrupt enable |
| cur_mpie | input | 1 | Machine previous enable |
| cur_mpp | input | 2 | Machine previous privilege |
| ideleg | input | XLEN | Interrupt delegation mask |
| edeleg | input | XLEN | Exception delegation mask |
| stvec | input | XLEN | Supervisor trap vector |
| mtvec | input | XLEN | Machine trap vector |
| nxt_pc | output | XLEN | Redirected program counter |
| nxt_priv | output | 2 | New privilege |
| nxt_sie | output | 1 | New supervisor enable |
| nxt_spie | output | 1 | New supervisor previous enable |
| nxt_spp | output | 1 | New supervisor previous privilege |
| nxt_mie | output | 1 | New machine enable |
| nxt_mpie | output | 1 | New machine previous enable |
| nxt_mpp | output | 2 | New machine previous privilege |
| s_cause | output | XLEN | Supervisor cause register |
| s_epc | output | XLEN | Supervisor exception pc |
| s_tval | output | XLEN | Supervisor trap value |
| m_cause | output | XLEN | Machine cause register |
| m_epc | output | XLEN | Machine exception pc |
| m_tval | output | XLEN | Machine trap value |
| resv_clear | output | 1 | Load reservation invalidate pulse |

## Verification
The bench goes after four corner cases:
- Cause codes at or above XLEN with every delegation bit set. A design that indexed the mask without a range check would route these to supervisor level.
- Environment calls from each privilege. A design that delegated on the raw code instead of the rewritten one would send a supervisor call to the wrong level.
- Vectored exceptions versus vectored interrupts. A design that added the offset to exceptions as well would jump into the interrupt table.
- Translation failures with protection and paging combinations. These expose a swapped page-fault and access-fault choice, or a leak of the ignored raw cause.

Random traps from machine privilege also check that the supervisor bank is left alone.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;

  localparam int unsigned EC_FETCH_MIS  = 0;
  localparam int unsigned EC_FETCH_ACC  = 1;
  localparam int unsigned EC_LOAD_MIS   = 4;
  localparam int unsigned EC_LOAD_ACC   = 5;
  localparam int unsigned EC_STORE_MIS  = 6;
  localparam int unsigned EC_STORE_ACC  = 7;
  localparam int unsigned EC_ECALL_BASE = 8;
  localparam int unsigned EC_FETCH_PG   = 12;
  localparam int unsigned EC_LOAD_PG    = 13;
  localparam int unsigned EC_STORE_PG   = 15;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2
  } acc_kind_t;
endpackage

// File: rtl/trap_cause_resolve.sv
module trap_cause_resolve
  import trap_pkg::*;
#(
  parameter int CW = 6
) (
  input  logic          irq_in,
  input  logic [CW-1:0] cause_in,
  input  logic          xlat_fail,
  input  logic [1:0]    xlat_kind,
  input  logic          paging_on,
  input  logic          prot_fail,
  input  logic [1:0]    priv,
  output logic          eff_irq,
  output logic [CW-1:0] eff_cause,
  output logic          keeps_addr
);
  acc_kind_t kind;
  logic      as_page;
  logic [CW-1:0] xlat_code;

  always_comb begin
    if (xlat_kind[1])      kind = ACC_STORE;
    else if (xlat_kind[0]) kind = ACC_LOAD;
    else                   kind = ACC_FETCH;
  end

  assign as_page = paging_on && !prot_fail;

  always_comb begin
    unique case (kind)
      ACC_FETCH: xlat_code = as_page ? CW'(EC_FETCH_PG) : CW'(EC_FETCH_ACC);
      ACC_LOAD:  xlat_code = as_page ? CW'(EC_LOAD_PG)  : CW'(EC_LOAD_ACC);
      default:   xlat_code = as_page ? CW'(EC_STORE_PG) : CW'(EC_STORE_ACC);
    endcase
  end

  always_comb begin
    if (xlat_fail) begin
      eff_irq   = 1'b0;
      eff_cause = xlat_code;
    end else if (!irq_in && cause_in == CW'(EC_ECALL_BASE)) begin
      eff_irq   = 1'b0;
      eff_cause = CW'(EC_ECALL_BASE) + {{(CW-2){1'b0}}, priv};
    end else begin
      eff_irq   = irq_in;
      eff_cause = cause_in;
    end
  end

  always_comb begin
    keeps_addr = 1'b0;
    if (!eff_irq) begin
      case (eff_cause)
        CW'(EC_FETCH_MIS), CW'(EC_FETCH_ACC), CW'(EC_LOAD_MIS),
        CW'(EC_LOAD_ACC), CW'(EC_STORE_MIS), CW'(EC_STORE_ACC),
        CW'(EC_FETCH_PG), CW'(EC_LOAD_PG), CW'(EC_STORE_PG): keeps_addr = 1'b1;
        default: keeps_addr = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/trap_route.sv
module trap_route
  import trap_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int CW   = 6
) (
  input  logic            irq,
  input  logic [CW-1:0]   cause,
  input  logic [1:0]      priv,
  input  logic [XLEN-1:0] ideleg,
  input  logic [XLEN-1:0] edeleg,
  output logic            to_super
);
  localparam int IW = $clog2(XLEN);

  logic            in_range;
  logic [XLEN-1:0] mask;

  generate
    if (CW > IW) begin : g_range_chk
      assign in_range = ~|cause[CW-1:IW];
    end else begin : g_range_all
      assign in_range = 1'b1;
    end
  endgenerate

  assign mask     = irq ? ideleg : edeleg;
  assign to_super = (priv == PRIV_U || priv == PRIV_S) && in_range && mask[cause[IW-1:0]];
endmodule

// File: rtl/trap_vector.sv
module trap_vector #(
  parameter int XLEN = 32,
  parameter int CW   = 6
) (
  input  logic [XLEN-1:0] tvec,
  input  logic            irq,
  input  logic [CW-1:0]   cause,
  output logic [XLEN-1:0] target
);
  logic [XLEN-1:0] base;
  logic [XLEN-1:0] offset;

  assign base   = {tvec[XLEN-1:2], 2'b00};
  assign offset = (irq && tvec[1:0] == 2'b01) ? {{(XLEN-CW-2){1'b0}}, cause, 2'b00} : '0;
  assign target = base + offset;
endmodule

// File: rtl/trap_level_bank.sv
module trap_level_bank #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr,
  input  logic [XLEN-1:0] cause_in,
  input  logic [XLEN-1:0] epc_in,
  input  logic [XLEN-1:0] tval_in,
  output logic [XLEN-1:0] cause_q,
  output logic [XLEN-1:0] epc_q,
  output logic [XLEN-1:0] tval_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cause_q <= '0;
      epc_q   <= '0;
      tval_q  <= '0;
    end else if (wr) begin
      cause_q <= cause_in;
      epc_q   <= epc_in;
      tval_q  <= tval_in;
    end
  end

  p_bank_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !wr |=> $stable(cause_q) && $stable(epc_q) && $stable(tval_q));

  p_epc_taken_r5: assert property (@(posedge clk) disable iff (rst)
    wr |=> epc_q == $past(epc_in));
endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
  import trap_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int CW   = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            trap_req,
  input  logic            trap_irq,
  input  logic [CW-1:0]   trap_cause,
  input  logic [XLEN-1:0] trap_addr,
  input  logic            xlat_fail,
  input  logic [1:0]      xlat_kind,
  input  logic            paging_on,
  input  logic            prot_fail,
  input  logic [XLEN-1:0] cur_pc,
  input  logic [1:0]      cur_priv,
  input  logic            cur_sie,
  input  logic            cur_spie,
  input  logic            cur_spp,
  input  logic            cur_mie,
  input  logic            cur_mpie,
  input  logic [1:0]      cur_mpp,
  input  logic [XLEN-1:0] ideleg,
  input  logic [XLEN-1:0] edeleg,
  input  logic [XLEN-1:0] stvec,
  input  logic [XLEN-1:0] mtvec,
  output logic [XLEN-1:0] nxt_pc,
  output logic [1:0]      nxt_priv,
  output logic            nxt_sie,
  output logic            nxt_spie,
  output logic            nxt_spp,
  output logic            nxt_mie,
  output logic            nxt_mpie,
  output logic [1:0]      nxt_mpp,
  output logic [XLEN-1:0] s_cause,
  output logic [XLEN-1:0] s_epc,
  output logic [XLEN-1:0] s_tval,
  output logic [XLEN-1:0] m_cause,
  output logic [XLEN-1:0] m_epc,
  output logic [XLEN-1:0] m_tval,
  output logic            resv_clear
);
  localparam int NLEV = 2;
  localparam int PAD  = XLEN - 1 - CW;

  logic            eff_irq;
  logic [CW-1:0]   eff_cause;
  logic            keeps_addr;
  logic            to_super;
  logic [XLEN-1:0] tvec_sel;
  logic [XLEN-1:0] target;
  logic [XLEN-1:0] cause_word;
  logic [XLEN-1:0] tval_word;

  trap_cause_resolve #(.CW(CW)) u_resolve (
    .irq_in(trap_irq), .cause_in(trap_cause), .xlat_fail(xlat_fail),
    .xlat_kind(xlat_kind), .paging_on(paging_on), .prot_fail(prot_fail),
    .priv(cur_priv), .eff_irq(eff_irq), .eff_cause(eff_cause),
    .keeps_addr(keeps_addr)
  );

  trap_route #(.XLEN(XLEN), .CW(CW)) u_route (
    .irq(eff_irq), .cause(eff_cause), .priv(cur_priv),
    .ideleg(ideleg), .edeleg(edeleg), .to_super(to_super)
  );

  assign tvec_sel = to_super ? stvec : mtvec;

  trap_vector #(.XLEN(XLEN), .CW(CW)) u_vector (
    .tvec(tvec_sel), .irq(eff_irq), .cause(eff_cause), .target(target)
  );

  assign cause_word = {eff_irq, {PAD{1'b0}}, eff_cause};
  assign tval_word  = keeps_addr ? trap_addr : '0;

  logic [XLEN-1:0] bank_cause [NLEV];
  logic [XLEN-1:0] bank_epc   [NLEV];
  logic [XLEN-1:0] bank_tval  [NLEV];

  generate
    for (genvar g = 0; g < NLEV; g++) begin : g_bank
      logic sel;
      assign sel = (g == 0) ? to_super : !to_super;
      trap_level_bank #(.XLEN(XLEN)) u_bank (
        .clk(clk), .rst(rst), .wr(trap_req && sel),
        .cause_in(cause_word), .epc_in(cur_pc), .tval_in(tval_word),
        .cause_q(bank_cause[g]), .epc_q(bank_epc[g]), .tval_q(bank_tval[g])
      );
    end
  endgenerate

  assign s_cause = bank_cause[0];
  assign s_epc   = bank_epc[0];
  assign s_tval  = bank_tval[0];
  assign m_cause = bank_cause[1];
  assign m_epc   = bank_epc[1];
  assign m_tval  = bank_tval[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      nxt_pc     <= '0;
      nxt_priv   <= PRIV_M;
      nxt_sie    <= 1'b0;
      nxt_spie   <= 1'b0;
      nxt_spp    <= 1'b0;
      nxt_mie    <= 1'b0;
      nxt_mpie   <= 1'b0;
      nxt_mpp    <= 2'b00;
      resv_clear <= 1'b0;
    end else begin
      resv_clear <= trap_req;
      if (trap_req) begin
        nxt_pc <= target;
        if (to_super) begin
          nxt_priv <= PRIV_S;
          nxt_sie  <= 1'b0;
          nxt_spie <= cur_sie;
          nxt_spp  <= cur_priv[0];
          nxt_mie  <= cur_mie;
          nxt_mpie <= cur_mpie;
          nxt_mpp  <= cur_mpp;
        end else begin
          nxt_priv <= PRIV_M;
          nxt_mie  <= 1'b0;
          nxt_mpie <= cur_mie;
          nxt_mpp  <= cur_priv;
          nxt_sie  <= cur_sie;
          nxt_spie <= cur_spie;
          nxt_spp  <= cur_spp;
        end
      end
    end
  end

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !trap_req |=> $stable(nxt_pc) && $stable(nxt_priv) && $stable(nxt_mpp) && !resv_clear);

  p_level_legal_r3: assert property (@(posedge clk) disable iff (rst)
    trap_req |=> (nxt_priv == PRIV_S || nxt_priv == PRIV_M));

  p_machine_from_m_r3: assert property (@(posedge clk) disable iff (rst)
    trap_req && cur_priv == PRIV_M |=> nxt_priv == PRIV_M);

  p_enable_off_r4: assert property (@(posedge clk) disable iff (rst)
    trap_req |=> (nxt_priv == PRIV_M) ? !nxt_mie : !nxt_sie);

  p_exc_aligned_r7: assert property (@(posedge clk) disable iff (rst)
    trap_req && !trap_irq |=> nxt_pc[1:0] == 2'b00);

  p_resv_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    trap_req |=> resv_clear);
endmodule

// File: tb/trap_entry_unit_test.sv
module trap_entry_unit_test;
  localparam int XLEN = 32;
  localparam int CW   = 6;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst, trap_req, trap_irq, xlat_fail, paging_on, prot_fail;
  logic [CW-1:0] trap_cause;
  logic [31:0] trap_addr, cur_pc, ideleg, edeleg, stvec, mtvec;
  logic [1:0] xlat_kind, cur_priv, cur_mpp;
  logic cur_sie, cur_spie, cur_spp, cur_mie, cur_mpie;
  logic [31:0] nxt_pc, s_cause, s_epc, s_tval, m_cause, m_epc, m_tval;
  logic [1:0] nxt_priv, nxt_mpp;
  logic nxt_sie, nxt_spie, nxt_spp, nxt_mie, nxt_mpie, resv_clear;

  trap_entry_unit #(.XLEN(XLEN), .CW(CW)) uut (.*);

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [31:0] e_pc, e_sc, e_se, e_st, e_mc, e_me, e_mt;
  logic [1:0]  e_priv, e_mpp;
  logic e_sie, e_spie, e_spp, e_mie, e_mpie, e_resv;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model(input bit req);
    bit irq, to_s, keep;
    int c;
    logic [31:0] m, tv, cw;
    e_resv = req;
    if (!req) return;
    if (xlat_fail) begin
      irq = 0;
      if (xlat_kind[1]) c = (paging_on && !prot_fail) ? 15 : 7;
      else if (xlat_kind[0]) c = (paging_on && !prot_fail) ? 13 : 5;
      else c = (paging_on && !prot_fail) ? 12 : 1;
    end else begin
      irq = trap_irq;
      c = int'(trap_cause);
      if (!irq && c == 8) c = 8 + int'(cur_priv);
    end
    m = irq ? ideleg : edeleg;
    to_s = (cur_priv <= 2'd1) && (c < 32) && m[c % 32];
    keep = !irq && (c inside {0, 1, 4, 5, 6, 7, 12, 13, 15});
    cw = (32'(irq) << 31) | 32'(c);
    tv = to_s ? stvec : mtvec;
    e_pc = (tv & ~32'd3) + ((irq && tv[1:0] == 2'd1) ? 32'(c) * 4 : 0);
    if (to_s) begin
      e_priv = 2'd1; e_sie = 0; e_spie = cur_sie; e_spp = cur_priv[0];
      e_mie = cur_mie; e_mpie = cur_mpie; e_mpp = cur_mpp;
      e_sc = cw; e_se = cur_pc; e_st = keep ? trap_addr : 0;
    end else begin
      e_priv = 2'd3; e_mie = 0; e_mpie = cur_mie; e_mpp = cur_priv;
      e_sie = cur_sie; e_spie = cur_spie; e_spp = cur_spp;
      e_mc = cw; e_me = cur_pc; e_mt = keep ? trap_addr : 0;
    end
  endtask

  task automatic compare_all(input bit req);
    string t;
    t = req ? "" : "R2 ";
    chk({t, "R7 pc"}, nxt_pc, e_pc);
    chk({t, "R3 priv"}, 32'(nxt_priv), 32'(e_priv));
    chk({t, "R4 status"}, {26'd0, nxt_sie, nxt_spie, nxt_spp, nxt_mie, nxt_mpie, 1'b0} | 32'(nxt_mpp) << 8,
        {26'd0, e_sie, e_spie, e_spp, e_mie, e_mpie, 1'b0} | 32'(e_mpp) << 8);
    chk({t, "R6 s_cause"}, s_cause, e_sc);
    chk({t, "R6 m_cause"}, m_cause, e_mc);
    chk({t, "R5 epc"}, s_epc ^ (m_epc << 1), e_se ^ (e_me << 1));
    chk({t, "R8 tval"}, s_tval ^ (m_tval << 1), e_st ^ (e_mt << 1));
    chk({t, "R11 resv"}, 32'(resv_clear), 32'(e_resv));
  endtask

  task automatic step(input bit req);
    trap_req = req;
    model(req);
    @(posedge clk);
    @(negedge clk);
    compare_all(req);
    trap_req = 0;
  endtask

  task automatic clear_in();
    trap_irq = 0; trap_cause = 0; trap_addr = 32'hA5A5_0000; xlat_fail = 0;
    xlat_kind = 0; paging_on = 0; prot_fail = 0; cur_pc = 32'h1000;
    cur_priv = 0; cur_sie = 1; cur_spie = 0; cur_spp = 0; cur_mie = 1;
    cur_mpie = 0; cur_mpp = 0; ideleg = 0; edeleg = 0;
    stvec = 32'h0000_4000; mtvec = 32'h0000_8000;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240607));
    rst = 1; trap_req = 0; clear_in();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    e_pc = 0; e_priv = 3; e_sie = 0; e_spie = 0; e_spp = 0; e_mie = 0;
    e_mpie = 0; e_mpp = 0; e_sc = 0; e_se = 0; e_st = 0; e_mc = 0;
    e_me = 0; e_mt = 0; e_resv = 0;
    // R1 reset state
    chk("R1 priv", 32'(nxt_priv), 32'd3);
    chk("R1 pc", nxt_pc, 0);
    chk("R1 banks", s_cause | s_epc | s_tval | m_cause | m_epc | m_tval, 0);
    chk("R1 resv", 32'(resv_clear), 0);

    // R9 environment calls from each privilege, all exceptions delegated
    edeleg = '1; trap_cause = 8;
    cur_priv = 0; step(1); chk("R9 user call", s_cause, 8);
    cur_priv = 1; step(1); chk("R9 super call", s_cause, 9);
    cur_priv = 3; step(1); chk("R9 machine call", m_cause, 11);
    // R9 delegation uses rewritten code: only bit 9 set
    edeleg = 32'h0000_0200; cur_priv = 0; step(1);
    chk("R9 user call to machine", 32'(nxt_priv), 3);
    cur_priv = 1; step(1); chk("R9 super call delegated", 32'(nxt_priv), 1);

    // R10 translation failures
    clear_in(); xlat_fail = 1; trap_irq = 1; trap_cause = 6'd3;
    xlat_kind = 1; paging_on = 1; step(1); chk("R10 load page", m_cause, 13);
    xlat_kind = 3; prot_fail = 1; step(1); chk("R10 store prot", m_cause, 7);
    xlat_kind = 0; prot_fail = 0; paging_on = 0; step(1); chk("R10 fetch bare", m_cause, 1);
    xlat_kind = 2; paging_on = 1; step(1); chk("R10 store page", m_cause, 15);

    // R7 vectored interrupt versus vectored exception
    clear_in(); mtvec = 32'h0000_8001; trap_irq = 1; trap_cause = 7;
    step(1); chk("R7 vectored irq", nxt_pc, 32'h0000_801C);
    trap_irq = 0; trap_cause = 2; step(1); chk("R7 vectored exc", nxt_pc, 32'h0000_8000);

    // R3 cause beyond XLEN with full delegation
    clear_in(); ideleg = '1; edeleg = '1; trap_irq = 1; trap_cause = 6'd33;
    step(1); chk("R3 wide cause to machine", 32'(nxt_priv), 3);
    trap_cause = 6'd1; step(1); chk("R3 irq delegated", 32'(nxt_priv), 1);

    // R2 no request, inputs churn
    mtvec = 32'hFFFF_0000; cur_pc = 32'hDEAD_BEE0; step(0); step(0);

    // random traffic
    for (int i = 0; i < 600; i++) begin
      trap_irq   = $urandom % 3 == 0;
      trap_cause = 6'($urandom % 40);
      trap_addr  = $urandom; cur_pc = $urandom;
      xlat_fail  = $urandom % 6 == 0; xlat_kind = 2'($urandom);
      paging_on  = 1'($urandom); prot_fail = 1'($urandom);
      case ($urandom % 4) 0: cur_priv = 0; 1: cur_priv = 1; 2: cur_priv = 3; default: cur_priv = 2; endcase
      {cur_sie, cur_spie, cur_spp, cur_mie, cur_mpie} = 5'($urandom);
      cur_mpp = 2'($urandom);
      ideleg = $urandom; edeleg = $urandom;
      stvec = $urandom; mtvec = $urandom;
      if ($urandom % 3 == 0) stvec[1:0] = 2'b01;
      if ($urandom % 3 == 0) mtvec[1:0] = 2'b01;
      step($urandom % 4 != 0);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule